// File: doc/BRIEF.md
# Half-width custom floating-point multiplier

This block multiplies two 16-bit floating-point words and returns their product in the same encoding. Each word holds a sign bit on top, a 4-bit exponent field with a bias of 7 below it, and 11 stored fraction bits at the bottom. An exponent field of all ones is a NaN, whatever the fraction holds. The format has no infinity. An exponent field of zero marks a subnormal: its leading bit is 0 and it uses the same scale as field 1.

Operands are offered with a valid/ready pair. The product, together with four status flags, appears in an output register with a one-cycle valid strobe. The datapath decodes both operands and multiplies the 12-bit significands. It then normalizes the product, handling results that land in the subnormal range, rounds to nearest by adding back the most significant discarded bit, and repacks the word. A parameter can insert one extra register between the multiplier and the rounding logic.

Top module: `mf16_mul`

## Requirements
- R1: For normal operands the product has sign, exponent field (bias 7) and 11-bit fraction correctly placed in bits 15, 14..11 and 10..0. A non-NaN result never carries exponent field 1111.
- R2: A subnormal operand (exponent field 0000) has leading bit 0 and scale 2^-6, so 0x0001 times 2.0 (0x4000) gives 0x0002.
- R3: If either operand has exponent field 1111, the result is 0x7C00 with only the NaN flag set. This includes NaN times zero.
- R4: The result sign is the XOR of the operand signs, and zero results follow the same rule (0x0000 times 0xC400 gives 0x8000).
- R5: Rounding adds the most significant discarded bit to the kept significand, so an exact half rounds away from zero. The inexact flag (flag bit 0) is set whenever any discarded bit is nonzero.
- R6: A rounding carry that reaches 2.0 renormalizes to fraction 0 and adds one to the exponent. A subnormal that rounds up becomes exponent field 0001.
- R7: A result whose exponent field would reach 1111 after rounding saturates to magnitude 0x77FF with the product's sign. It raises the overflow flag (bit 2) and the inexact flag.
- R8: Tiny results become subnormals. Products of at least 2^-18 and below 2^-17 round to 0x0001, and smaller ones flush to a signed zero. The underflow flag (bit 1) is set when the pre-rounding exponent is in the subnormal range and the result is inexact.
- R9: in_ready is low during reset and high from the first clock edge after it. out_valid is low after reset and is high exactly in the cycle after each accepted input, with the default single-stage setting.
- R10: The largest finite value 0x77FF times 1.0 returns 0x77FF with no flags set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block accepts operands |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result register holds a new product |
| out_data | output | 16 | Product word |
| out_nan | output | 1 | Flag bit 3: NaN result |
| out_ovf | output | 1 | Flag bit 2: saturated on overflow |
| out_unf | output | 1 | Flag bit 1: tiny and inexact |
| out_inx | output | 1 | Flag bit 0: rounded result differs from exact product |

## Verification
The output assertions assume every handshake cycle carries defined operand bits. The sign assertion also assumes operands are sampled only in the cycle they are accepted. The stimulus changes in_a and in_b only at falling edges and raises in_valid only with fully specified words. The bench never leaves operands floating while in_valid is high, and it streams vectors back to back so that each output cycle traces to exactly one accepted input. Corner operands are chosen by hand so that the exact product sits on a rounding or range boundary: an exact half, a carry to 2.0, the subnormal edge, and the overflow edge.

// File: rtl/mf16_pkg.sv
package mf16_pkg;
   typedef struct packed {
      logic nan;
      logic ovf;
      logic unf;
      logic inx;
   } mf_flags_t;
endpackage

// File: rtl/mf16_unpack.sv
module mf16_unpack #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 11
) (
   input  logic [EXP_W+MAN_W:0] op,
   output logic                 sign,
   output logic                 is_nan,
   output logic                 is_zero,
   output logic [EXP_W-1:0]     eff_exp,
   output logic [MAN_W:0]       sig
);
   localparam int W = EXP_W + MAN_W + 1;

   logic [EXP_W-1:0] fld;
   logic             sub;

   assign fld     = op[W-2:MAN_W];
   assign sub     = (fld == '0);
   assign sign    = op[W-1];
   assign is_nan  = (fld == '1);
   assign is_zero = sub && (op[MAN_W-1:0] == '0);
   // subnormals share the scale of exponent field 1
   assign eff_exp = sub ? EXP_W'(1) : fld;
   assign sig     = {~sub, op[MAN_W-1:0]};
endmodule

// File: rtl/mf16_sigmul.sv
module mf16_sigmul #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 11
) (
   input  logic [EXP_W+MAN_W:0]   a,
   input  logic [EXP_W+MAN_W:0]   b,
   output logic                   p_sign,
   output logic                   p_nan,
   output logic                   p_zero,
   output logic [EXP_W:0]         p_esum,
   output logic [2*MAN_W+1:0]     p_prod
);
   localparam int SIG_W  = MAN_W + 1;
   localparam int PROD_W = 2 * SIG_W;

   logic             sa, sb, na, nb, za, zb;
   logic [EXP_W-1:0] ea, eb;
   logic [SIG_W-1:0] ma, mb;

   mf16_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ua (
      .op(a), .sign(sa), .is_nan(na), .is_zero(za), .eff_exp(ea), .sig(ma));
   mf16_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ub (
      .op(b), .sign(sb), .is_nan(nb), .is_zero(zb), .eff_exp(eb), .sig(mb));

   assign p_sign = sa ^ sb;
   assign p_nan  = na | nb;
   assign p_zero = za | zb;
   assign p_esum = {1'b0, ea} + {1'b0, eb};
   assign p_prod = PROD_W'(ma) * PROD_W'(mb);
endmodule

// File: rtl/mf16_round.sv
module mf16_round
   import mf16_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 11
) (
   input  logic                 sign,
   input  logic                 nan_in,
   input  logic                 zero_in,
   input  logic [EXP_W:0]       esum,
   input  logic [2*MAN_W+1:0]   prod,
   output logic [EXP_W+MAN_W:0] res,
   output mf_flags_t            flags
);
   localparam int SIG_W  = MAN_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int EMAX   = (1 << EXP_W) - 1;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int LZ_W   = $clog2(PROD_W) + 1;
   localparam int BE_W   = EXP_W + LZ_W + 2;
   localparam int K_MAX  = SIG_W + 1;
   localparam int K_W    = $clog2(K_MAX + 1) + 1;

   logic [LZ_W-1:0]   lz;
   logic [PROD_W-1:0] pn, sh;
   logic [BE_W-1:0]   be, kraw, e_big;
   logic              tiny, guard, lost, ovf;
   logic [K_W-1:0]    k;
   logic [SIG_W-1:0]  kept;
   logic [SIG_W:0]    rnd;
   logic [EXP_W-1:0]  e_fin;

   always_comb begin
      lz = '0;
      for (int i = 0; i < PROD_W; i++)
         if (prod[i]) lz = LZ_W'(PROD_W - 1 - i);
      pn   = prod << lz;
      // biased exponent of the normalized product, before rounding
      be   = BE_W'(esum) - BE_W'(BIAS) + BE_W'(1) - BE_W'(lz);
      tiny = be[BE_W-1] | (be == '0);
      kraw = BE_W'(1) - be;
      if (!tiny)                     k = '0;
      else if (kraw > BE_W'(K_MAX))  k = K_W'(K_MAX);
      else                           k = K_W'(kraw);
      sh    = pn >> k;
      kept  = sh[PROD_W-1 -: SIG_W];
      guard = sh[MAN_W];
      lost  = ((sh << k) != pn) || (sh[MAN_W:0] != '0);
      rnd   = {1'b0, kept} + (SIG_W+1)'(guard);
      e_big = be + BE_W'(rnd[SIG_W]);
      ovf   = !tiny && (e_big >= BE_W'(EMAX));
      if (tiny) e_fin = rnd[MAN_W] ? EXP_W'(1) : '0;
      else      e_fin = e_big[EXP_W-1:0];

      flags = '0;
      if (nan_in) begin
         res       = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
         flags.nan = 1'b1;
      end else if (zero_in) begin
         res = {sign, {(EXP_W+MAN_W){1'b0}}};
      end else if (ovf) begin
         res       = {sign, EXP_W'(EMAX - 1), {MAN_W{1'b1}}};
         flags.ovf = 1'b1;
         flags.inx = 1'b1;
      end else begin
         res       = {sign, e_fin, rnd[MAN_W-1:0]};
         flags.inx = lost;
         flags.unf = tiny & lost;
      end
   end
endmodule

// File: rtl/mf16_mul.sv
module mf16_mul
   import mf16_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 11,
   parameter int PIPE  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [EXP_W+MAN_W:0] in_a,
   input  logic [EXP_W+MAN_W:0] in_b,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] out_data,
   output logic                 out_nan,
   output logic                 out_ovf,
   output logic                 out_unf,
   output logic                 out_inx
);
   localparam int W      = EXP_W + MAN_W + 1;
   localparam int PROD_W = 2 * (MAN_W + 1);
   localparam logic [W-1:0]   NAN_PAT = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [W-2:0]   MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

   if (EXP_W < 3 || MAN_W < 2) begin : g_bad_width
      $error("mf16_mul: EXP_W must be >= 3 and MAN_W >= 2");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_bad_pipe
      $error("mf16_mul: PIPE must be 0 or 1");
   end

   logic              accept, rdy_q;
   logic              m_sign, m_nan, m_zero;
   logic [EXP_W:0]    m_esum;
   logic [PROD_W-1:0] m_prod;
   logic              s_valid, s_sign, s_nan, s_zero;
   logic [EXP_W:0]    s_esum;
   logic [PROD_W-1:0] s_prod;
   logic [W-1:0]      r_res;
   mf_flags_t         r_flags, o_flags;

   assign in_ready = rdy_q;
   assign accept   = in_valid & rdy_q;

   mf16_sigmul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mul (
      .a(in_a), .b(in_b), .p_sign(m_sign), .p_nan(m_nan), .p_zero(m_zero),
      .p_esum(m_esum), .p_prod(m_prod));

   if (PIPE == 1) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_valid <= 1'b0;
            s_sign  <= 1'b0;
            s_nan   <= 1'b0;
            s_zero  <= 1'b0;
            s_esum  <= '0;
            s_prod  <= '0;
         end else begin
            s_valid <= accept;
            if (accept) begin
               s_sign <= m_sign;
               s_nan  <= m_nan;
               s_zero <= m_zero;
               s_esum <= m_esum;
               s_prod <= m_prod;
            end
         end
      end
      a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(accept, 2));
   end else begin : g_direct
      assign s_valid = accept;
      assign s_sign  = m_sign;
      assign s_nan   = m_nan;
      assign s_zero  = m_zero;
      assign s_esum  = m_esum;
      assign s_prod  = m_prod;
      a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(accept));
      a_r4_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_nan |-> out_data[W-1] == $past(in_a[W-1] ^ in_b[W-1]));
   end

   mf16_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
      .sign(s_sign), .nan_in(s_nan), .zero_in(s_zero), .esum(s_esum),
      .prod(s_prod), .res(r_res), .flags(r_flags));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         o_flags   <= '0;
      end else begin
         rdy_q     <= 1'b1;
         out_valid <= s_valid;
         if (s_valid) begin
            out_data <= r_res;
            o_flags  <= r_flags;
         end
      end
   end

   assign out_nan = o_flags.nan;
   assign out_ovf = o_flags.ovf;
   assign out_unf = o_flags.unf;
   assign out_inx = o_flags.inx;

   a_r3_nan_canonical: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_nan |-> out_data == NAN_PAT && !out_ovf && !out_unf && !out_inx);
   a_r7_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf |-> out_data[W-2:0] == MAX_MAG && out_inx && !out_unf);
   a_r1_no_reserved_exp: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_nan |-> out_data[W-2:MAN_W] != '1);
   a_r8_unf_tiny: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_unf |-> out_data[W-2:MAN_W] <= EXP_W'(1) && out_inx);
   a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready);
endmodule

// File: tb/mf16_mul_tb.sv
module mf16_mul_tb;
   localparam int NV = 22;
   // {a, b, expected product, flags {nan,ovf,unf,inx}}
   localparam logic [51:0] VEC [NV] = '{
      {16'h3C00, 16'h4000, 16'h4400, 4'h0},  // R1 1.5*2
      {16'h3C00, 16'h3C00, 16'h4100, 4'h0},  // R1 1.5*1.5
      {16'hB800, 16'h4000, 16'hC000, 4'h0},  // R4
      {16'hBC00, 16'hBC00, 16'h4100, 4'h0},  // R4
      {16'h0000, 16'hC400, 16'h8000, 4'h0},  // R4 signed zero
      {16'h7801, 16'h3800, 16'h7C00, 4'h8},  // R3
      {16'hF800, 16'h0000, 16'h7C00, 4'h8},  // R3 NaN*0
      {16'h77FF, 16'h3800, 16'h77FF, 4'h0},  // R10
      {16'h77FF, 16'h4000, 16'h77FF, 4'h5},  // R7
      {16'hF7FF, 16'h4000, 16'hF7FF, 4'h5},  // R7 negative
      {16'h7001, 16'h3FFE, 16'h77FF, 4'h5},  // R7 via rounding carry
      {16'h3801, 16'h3801, 16'h3802, 4'h1},  // R5 below half
      {16'h3801, 16'h3C00, 16'h3C02, 4'h1},  // R5 exact half up
      {16'h3FFF, 16'h3C00, 16'h43FF, 4'h1},  // R5 truncating case
      {16'h3801, 16'h3FFE, 16'h4000, 4'h1},  // R6 carry to 2.0
      {16'h07FF, 16'h3801, 16'h0800, 4'h3},  // R6 subnormal to normal
      {16'h0001, 16'h4000, 16'h0002, 4'h0},  // R2
      {16'h0123, 16'h3800, 16'h0123, 4'h0},  // R2
      {16'h0001, 16'h0001, 16'h0000, 4'h3},  // R8 flush
      {16'h8001, 16'h0001, 16'h8000, 4'h3},  // R8 signed flush
      {16'h0001, 16'h3000, 16'h0001, 4'h3},  // R8 exactly half of min
      {16'h0001, 16'h2FFF, 16'h0000, 4'h3}   // R8 below half
   };
   string tag [NV] = '{"R1", "R1", "R4", "R4", "R4", "R3", "R3", "R10", "R7", "R7", "R7",
                       "R5", "R5", "R5", "R6", "R6", "R2", "R2", "R8", "R8", "R8", "R8"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_a = '0, in_b = '0;
   logic        in_ready, out_valid, out_nan, out_ovf, out_unf, out_inx;
   logic [15:0] out_data;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   mf16_mul u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data),
      .out_nan(out_nan), .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_vec(input int i);
      logic [3:0] fl;
      fl = {out_nan, out_ovf, out_unf, out_inx};
      chk(out_valid == 1'b1, {tag[i], " valid"}, 32'(out_valid), 32'h1);
      chk(out_data == VEC[i][19:4], {tag[i], " data"}, 32'(out_data), 32'(VEC[i][19:4]));
      chk(fl == VEC[i][3:0], {tag[i], " flags"}, 32'(fl), 32'(VEC[i][3:0]));
   endtask

   initial begin
      #2;
      // R9: reset state
      chk(in_ready == 1'b0, "R9 ready in reset", 32'(in_ready), 32'h0);
      chk(out_valid == 1'b0, "R9 valid in reset", 32'(out_valid), 32'h0);
      chk(out_data == 16'h0, "R9 data in reset", 32'(out_data), 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1, "R9 ready after reset", 32'(in_ready), 32'h1);
      chk(out_valid == 1'b0, "R9 idle no valid", 32'(out_valid), 32'h0);

      // streamed vectors, one per cycle
      for (int i = 0; i < NV; i++) begin
         if (i > 0) chk_vec(i - 1);
         in_a     = VEC[i][51:36];
         in_b     = VEC[i][35:20];
         in_valid = 1'b1;
         @(negedge clk);
      end
      chk_vec(NV - 1);
      in_valid = 1'b0;
      in_a     = 16'h3C00;
      in_b     = 16'h3C00;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 no valid without input", 32'(out_valid), 32'h0);
      chk(out_data == VEC[NV-1][19:4], "R9 output held", 32'(out_data), 32'(VEC[NV-1][19:4]));

      // R4 directed: negative subnormal times positive normal
      in_a = 16'h8123; in_b = 16'h3800; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_data == 16'h8123, "R4 negative subnormal", 32'(out_data), 32'h8123);
      chk(out_valid == 1'b1, "R9 single accept", 32'(out_valid), 32'h1);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 strobe one cycle", 32'(out_valid), 32'h0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%h expected=%h", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule